// File: doc/BRIEF.md
# Multi-Mode Up/Down Position Counter

This block is the counting core of one motion axis. Each clock edge on which the count-enable pulse is high moves a 24-bit synchronous counter one step, up or down as the direction input says. A preset register, written from its own data port, can be copied into the counter by a load command. A latch command copies the counter into an output latch, which is the value a host would read. An equality flag reports when the counter matches the preset.

The preset also sets the behaviour at the ends of the count range. Four modes are available: free-running, modulo-N, range-limited and non-recycling. Each mode counts either in plain binary or in six-digit BCD. A one-cycle carry or borrow pulse marks every wrap, and every count that a limit blocks. Quadrature decoding and host bus framing sit outside this block.

Top module: `axis_count_core`

## Requirements
- R1: While rst_n is low, the counter, the output latch and the preset register are cleared, and carry_o and borrow_o are low.
- R2: preset_wr stores preset_in into the preset register at the clock edge. load_cnt copies the preset value held before that edge into the counter and clears the non-recycle freeze. A load overrides a count pulse in the same cycle, and no flag pulses on a load.
- R3: latch_cnt copies into latch_o the counter value from before the edge. A count step in the same cycle shows in count_o but not in the latch. The latch holds its value until the next latch_cnt.
- R4: In mode_sel 0 (free-running) with binary arithmetic, each enabled cycle adds 1 when cnt_up is 1 and subtracts 1 when it is 0. The count wraps from FFFFFF to 0 with a carry, and from 0 to FFFFFF with a borrow. carry_o and borrow_o are high for exactly the one cycle in which the new count appears.
- R5: With bcd_en high, the counter holds six decimal digits, 4 bits each, with digit k in bits 4k+3:4k. It counts in decimal. 999999 goes up to 000000 with a carry, and 000000 goes down to 999999 with a borrow.
- R6: In mode_sel 1 (modulo-N), an up step taken while the count equals the preset gives 0 and a carry. A down step taken at 0 gives the preset value and a borrow.
- R7: In mode_sel 2 (range limit), an up step taken at the preset value leaves the count unchanged and pulses carry. A down step taken at 0 leaves it unchanged and pulses borrow.
- R8: In mode_sel 3 (non-recycle), counting follows R4/R5 until a step wraps. That step produces the wrapped value and its carry or borrow, and then freezes the counter. Later count pulses are ignored, with no flags, until a load or a reset.
- R9: cmp_eq_o is high in every cycle in which the counter equals the preset register.
- R10: When cnt_en and load_cnt are both low, the count does not change and no carry or borrow pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count pulse: one step per high cycle |
| cnt_up | input | 1 | Direction: 1 up, 0 down |
| mode_sel | input | 2 | 0 free, 1 modulo-N, 2 range limit, 3 non-recycle |
| bcd_en | input | 1 | 1 for six-digit BCD arithmetic |
| preset_wr | input | 1 | Write preset_in into the preset register |
| preset_in | input | 24 | Preset data |
| load_cnt | input | 1 | Copy the preset into the counter |
| latch_cnt | input | 1 | Copy the counter into the output latch |
| count_o | output | 24 | Live counter value |
| latch_o | output | 24 | Output latch |
| carry_o | output | 1 | One-cycle carry or up-limit pulse |
| borrow_o | output | 1 | One-cycle borrow or down-limit pulse |
| cmp_eq_o | output | 1 | Counter equals preset |

## Verification
Two pairs of functions can act on the same edge. A latch command can coincide with a count step, and a load can coincide with a count pulse. The bench drives both inputs together in one cycle. For the first pair it expects the latch to hold the value from before the step and count_o to move. For the second it expects count_o to equal the preset with no flag. A preset write in the same cycle as a load is also driven, and the load must use the old preset.

// File: rtl/axc_pkg.sv
package axc_pkg;

    typedef enum logic [1:0] {
        CM_FREE    = 2'd0,
        CM_MODULO  = 2'd1,
        CM_RANGE   = 2'd2,
        CM_ONESHOT = 2'd3
    } cmode_e;

endpackage

// File: rtl/axc_bcd_digit.sv
// One decimal digit: increment and decrement with ripple carry/borrow.
module axc_bcd_digit (
    input  logic [3:0] dig,
    input  logic       inc_in,
    input  logic       dec_in,
    output logic [3:0] inc_val,
    output logic       inc_out,
    output logic [3:0] dec_val,
    output logic       dec_out
);
    always_comb begin
        inc_val = dig;
        inc_out = 1'b0;
        if (inc_in) begin
            if (dig >= 4'd9) begin
                inc_val = 4'd0;
                inc_out = 1'b1;
            end else begin
                inc_val = dig + 4'd1;
            end
        end
    end

    always_comb begin
        dec_val = dig;
        dec_out = 1'b0;
        if (dec_in) begin
            if (dig == 4'd0) begin
                dec_val = 4'd9;
                dec_out = 1'b1;
            end else begin
                dec_val = dig - 4'd1;
            end
        end
    end
endmodule

// File: rtl/axc_stepper.sv
// Computes both neighbours of the current count in the selected arithmetic.
module axc_stepper #(
    parameter int WIDTH = 24
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             bcd,
    output logic [WIDTH-1:0] up_val,
    output logic             up_wrap,
    output logic [WIDTH-1:0] dn_val,
    output logic             dn_wrap
);
    localparam int DIGITS = WIDTH / 4;

    logic [WIDTH-1:0] bcd_up;
    logic [WIDTH-1:0] bcd_dn;
    logic [DIGITS:0]  c_chain;
    logic [DIGITS:0]  b_chain;

    assign c_chain[0] = 1'b1;
    assign b_chain[0] = 1'b1;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        axc_bcd_digit u_dig (
            .dig     (cur[4*g +: 4]),
            .inc_in  (c_chain[g]),
            .dec_in  (b_chain[g]),
            .inc_val (bcd_up[4*g +: 4]),
            .inc_out (c_chain[g+1]),
            .dec_val (bcd_dn[4*g +: 4]),
            .dec_out (b_chain[g+1])
        );
    end

    always_comb begin
        if (bcd) begin
            up_val  = bcd_up;
            up_wrap = c_chain[DIGITS];
            dn_val  = bcd_dn;
            dn_wrap = b_chain[DIGITS];
        end else begin
            up_val  = cur + {{(WIDTH-1){1'b0}}, 1'b1};
            up_wrap = &cur;
            dn_val  = cur - {{(WIDTH-1){1'b0}}, 1'b1};
            dn_wrap = ~|cur;
        end
    end
endmodule

// File: rtl/axc_policy.sv
// Applies the end-of-range rule of the selected mode to one count step.
module axc_policy
    import axc_pkg::*;
#(
    parameter int WIDTH = 24
) (
    input  cmode_e           mode,
    input  logic             up,
    input  logic             frozen,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] lim,
    input  logic [WIDTH-1:0] up_val,
    input  logic             up_wrap,
    input  logic [WIDTH-1:0] dn_val,
    input  logic             dn_wrap,
    output logic [WIDTH-1:0] nxt,
    output logic             carry,
    output logic             borrow,
    output logic             freeze
);
    logic at_top;
    logic at_zero;

    assign at_top  = (cur == lim);
    assign at_zero = ~|cur;

    always_comb begin
        nxt    = cur;
        carry  = 1'b0;
        borrow = 1'b0;
        freeze = 1'b0;
        unique case (mode)
            CM_FREE: begin
                if (up) begin
                    nxt   = up_val;
                    carry = up_wrap;
                end else begin
                    nxt    = dn_val;
                    borrow = dn_wrap;
                end
            end
            CM_MODULO: begin
                if (up) begin
                    nxt   = at_top ? '0 : up_val;
                    carry = at_top;
                end else begin
                    nxt    = at_zero ? lim : dn_val;
                    borrow = at_zero;
                end
            end
            CM_RANGE: begin
                if (up) begin
                    nxt   = at_top ? cur : up_val;
                    carry = at_top;
                end else begin
                    nxt    = at_zero ? cur : dn_val;
                    borrow = at_zero;
                end
            end
            CM_ONESHOT: begin
                if (!frozen) begin
                    if (up) begin
                        nxt    = up_val;
                        carry  = up_wrap;
                        freeze = up_wrap;
                    end else begin
                        nxt    = dn_val;
                        borrow = dn_wrap;
                        freeze = dn_wrap;
                    end
                end
            end
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/axis_count_core.sv
module axis_count_core
    import axc_pkg::*;
#(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             cnt_up,
    input  logic [1:0]       mode_sel,
    input  logic             bcd_en,
    input  logic             preset_wr,
    input  logic [WIDTH-1:0] preset_in,
    input  logic             load_cnt,
    input  logic             latch_cnt,
    output logic [WIDTH-1:0] count_o,
    output logic [WIDTH-1:0] latch_o,
    output logic             carry_o,
    output logic             borrow_o,
    output logic             cmp_eq_o
);
    typedef struct packed {
        logic [WIDTH-1:0] count;
        logic [WIDTH-1:0] preset;
        logic [WIDTH-1:0] latch;
        logic             carry;
        logic             borrow;
        logic             frozen;
    } state_t;

    state_t st_d, st_q;

    logic [WIDTH-1:0] up_val, dn_val, pol_nxt;
    logic             up_wrap, dn_wrap, pol_carry, pol_borrow, pol_freeze;
    cmode_e           mode;

    assign mode = cmode_e'(mode_sel);

    axc_stepper #(.WIDTH(WIDTH)) u_step (
        .cur     (st_q.count),
        .bcd     (bcd_en),
        .up_val  (up_val),
        .up_wrap (up_wrap),
        .dn_val  (dn_val),
        .dn_wrap (dn_wrap)
    );

    axc_policy #(.WIDTH(WIDTH)) u_pol (
        .mode    (mode),
        .up      (cnt_up),
        .frozen  (st_q.frozen),
        .cur     (st_q.count),
        .lim     (st_q.preset),
        .up_val  (up_val),
        .up_wrap (up_wrap),
        .dn_val  (dn_val),
        .dn_wrap (dn_wrap),
        .nxt     (pol_nxt),
        .carry   (pol_carry),
        .borrow  (pol_borrow),
        .freeze  (pol_freeze)
    );

    always_comb begin
        st_d        = st_q;
        st_d.carry  = 1'b0;
        st_d.borrow = 1'b0;
        if (preset_wr) begin
            st_d.preset = preset_in;
        end
        if (latch_cnt) begin
            st_d.latch = st_q.count;
        end
        if (load_cnt) begin
            st_d.count  = st_q.preset;
            st_d.frozen = 1'b0;
        end else if (cnt_en) begin
            st_d.count  = pol_nxt;
            st_d.carry  = pol_carry;
            st_d.borrow = pol_borrow;
            st_d.frozen = st_q.frozen | pol_freeze;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o  = st_q.count;
    assign latch_o  = st_q.latch;
    assign carry_o  = st_q.carry;
    assign borrow_o = st_q.borrow;
    assign cmp_eq_o = (st_q.count == st_q.preset);

    logic [WIDTH-1:0] preset_q;
    logic             frozen_q;
    assign preset_q = st_q.preset;
    assign frozen_q = st_q.frozen;
endmodule

// File: rtl/axc_checker.sv
module axc_checker #(
    parameter int WIDTH = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic             cnt_up,
    input logic [1:0]       mode_sel,
    input logic             bcd_en,
    input logic             load_cnt,
    input logic             latch_cnt,
    input logic [WIDTH-1:0] count_o,
    input logic [WIDTH-1:0] latch_o,
    input logic             carry_o,
    input logic             borrow_o,
    input logic [WIDTH-1:0] preset_q,
    input logic             frozen_q
);
    localparam logic [WIDTH-1:0] BCD_TOP = WIDTH'(24'h999999);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !load_cnt) |=> ($stable(count_o) && !carry_o && !borrow_o));

    assert_load_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_cnt |=> (count_o == $past(preset_q) && !carry_o && !borrow_o));

    assert_latch_old_R3: assert property (@(posedge clk) disable iff (!rst_n)
        latch_cnt |=> (latch_o == $past(count_o)));

    assert_flags_apart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(carry_o && borrow_o));

    assert_bcd_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bcd_en && mode_sel == 2'd0 && cnt_en && cnt_up && !load_cnt && count_o == BCD_TOP)
        |=> (count_o == '0 && carry_o));

    assert_modulo_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd1 && cnt_en && cnt_up && !load_cnt && count_o == preset_q)
        |=> (count_o == '0 && carry_o));

    assert_range_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd2 && cnt_en && cnt_up && !load_cnt && count_o == preset_q)
        |=> ($stable(count_o) && carry_o));

    assert_frozen_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd3 && frozen_q && !load_cnt)
        |=> ($stable(count_o) && !carry_o && !borrow_o));
endmodule

bind axis_count_core axc_checker #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .cnt_up    (cnt_up),
    .mode_sel  (mode_sel),
    .bcd_en    (bcd_en),
    .load_cnt  (load_cnt),
    .latch_cnt (latch_cnt),
    .count_o   (count_o),
    .latch_o   (latch_o),
    .carry_o   (carry_o),
    .borrow_o  (borrow_o),
    .preset_q  (preset_q),
    .frozen_q  (frozen_q)
);

// File: tb/sim_axis_count_core.sv
`timescale 1ns/1ps
module sim_axis_count_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0, cnt_up = 1'b0, bcd_en = 1'b0;
    logic [1:0]  mode_sel = 2'd0;
    logic        preset_wr = 1'b0, load_cnt = 1'b0, latch_cnt = 1'b0;
    logic [23:0] preset_in = '0;
    logic [23:0] count_o, latch_o;
    logic        carry_o, borrow_o, cmp_eq_o;

    always #4 clk = ~clk;

    axis_count_core u0 (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_up(cnt_up),
        .mode_sel(mode_sel), .bcd_en(bcd_en), .preset_wr(preset_wr),
        .preset_in(preset_in), .load_cnt(load_cnt), .latch_cnt(latch_cnt),
        .count_o(count_o), .latch_o(latch_o), .carry_o(carry_o),
        .borrow_o(borrow_o), .cmp_eq_o(cmp_eq_o)
    );

    typedef struct {
        string       tag;
        logic [23:0] cnt;
        logic [23:0] lat;
        logic        cy;
        logic        bw;
        logic        eq;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 0;

    logic [23:0] m_cnt = '0, m_pre = '0, m_lat = '0;
    logic        m_frz = 1'b0;
    logic [1:0]  m_mode = 2'd0;
    logic        m_bcd = 1'b0;

    function automatic int bcd2int(input logic [23:0] v);
        int r = 0;
        for (int k = 5; k >= 0; k--) r = r * 10 + int'(v[4*k +: 4]);
        return r;
    endfunction

    function automatic logic [23:0] int2bcd(input int n);
        logic [23:0] r = '0;
        int t = n;
        for (int k = 0; k < 6; k++) begin
            r[4*k +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    // returns {wrap, value} for one plain step
    function automatic logic [24:0] step1(input logic [23:0] v, input logic up, input logic bcd);
        int n;
        if (bcd) begin
            n = bcd2int(v);
            if (up) return (n == 999999) ? {1'b1, 24'h0} : {1'b0, int2bcd(n + 1)};
            else    return (n == 0) ? {1'b1, 24'h999999} : {1'b0, int2bcd(n - 1)};
        end
        if (up) return (v == 24'hFFFFFF) ? {1'b1, 24'h0} : {1'b0, v + 24'd1};
        return (v == 24'h0) ? {1'b1, 24'hFFFFFF} : {1'b0, v - 24'd1};
    endfunction

    task automatic check(input string tag, input string what, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus and pushes the expected result
    task automatic drv(input string tag, input logic en, input logic up,
                       input logic ld, input logic lt, input logic pw, input logic [23:0] pin);
        exp_t e;
        logic [24:0] s;
        logic [23:0] nc, np, nl;
        logic cy = 1'b0, bw = 1'b0, nf;
        @(negedge clk);
        cnt_en = en; cnt_up = up; load_cnt = ld; latch_cnt = lt;
        preset_wr = pw; preset_in = pin; mode_sel = m_mode; bcd_en = m_bcd;
        nc = m_cnt; nf = m_frz;
        np = pw ? pin : m_pre;
        nl = lt ? m_cnt : m_lat;
        if (ld) begin
            nc = m_pre; nf = 1'b0;
        end else if (en) begin
            s = step1(m_cnt, up, m_bcd);
            case (m_mode)
                2'd0: begin nc = s[23:0]; cy = up & s[24]; bw = !up & s[24]; end
                2'd1: begin
                    if (up && m_cnt == m_pre)       begin nc = '0;    cy = 1'b1; end
                    else if (!up && m_cnt == 24'h0) begin nc = m_pre; bw = 1'b1; end
                    else nc = s[23:0];
                end
                2'd2: begin
                    if (up && m_cnt == m_pre)       cy = 1'b1;
                    else if (!up && m_cnt == 24'h0) bw = 1'b1;
                    else nc = s[23:0];
                end
                default: begin
                    if (!m_frz) begin
                        nc = s[23:0]; cy = up & s[24]; bw = !up & s[24]; nf = s[24];
                    end
                end
            endcase
        end
        m_cnt = nc; m_pre = np; m_lat = nl; m_frz = nf;
        e.tag = tag; e.cnt = nc; e.lat = nl; e.cy = cy; e.bw = bw; e.eq = (nc == np);
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        drv(tag, 0, 0, 0, 0, 0, 24'h0);
    endtask

    task automatic set_pre_load(input string tag, input logic [23:0] v);
        drv(tag, 0, 0, 0, 0, 1, v);
        drv(tag, 0, 0, 1, 0, 0, 24'h0);
    endtask

    // monitor: pops expected items after each active edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #3;
            if (q.size() > 0) begin
                e = q.pop_front();
                check(e.tag, "count",  count_o, e.cnt);
                check(e.tag, "latch",  latch_o, e.lat);
                check(e.tag, "carry",  {23'h0, carry_o},  {23'h0, e.cy});
                check(e.tag, "borrow", {23'h0, borrow_o}, {23'h0, e.bw});
                check(e.tag, "cmp_eq", {23'h0, cmp_eq_o}, {23'h0, e.eq});
            end
        end
    end

    task automatic finish_up;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "count",  count_o, 24'h0);
        check("R1", "latch",  latch_o, 24'h0);
        check("R1", "flags",  {22'h0, carry_o, borrow_o}, 24'h0);
        rst_n = 1'b1;

        // R2 and R9: preset write then load
        set_pre_load("R2", 24'h000010);
        // R4 binary counting
        drv("R4", 1, 1, 0, 0, 0, 0);
        drv("R4", 1, 1, 0, 0, 0, 0);
        drv("R4", 1, 0, 0, 0, 0, 0);
        // R10 idle, preset changes alone
        idle("R10");
        drv("R10", 0, 1, 0, 0, 1, 24'h000011);
        drv("R9", 0, 0, 0, 0, 1, 24'h000010);
        // R3 latch with a count step in the same cycle
        drv("R3", 1, 1, 0, 1, 0, 0);
        drv("R3", 1, 1, 0, 0, 0, 0);
        // R2 load with count pulse; load with preset write uses old preset
        drv("R2", 1, 1, 1, 0, 0, 0);
        drv("R2", 0, 0, 1, 0, 1, 24'h000077);
        // R4 wraps
        set_pre_load("R4", 24'hFFFFFF);
        drv("R4", 1, 1, 0, 0, 0, 0);
        drv("R4", 1, 0, 0, 0, 0, 0);
        drv("R4", 1, 0, 0, 0, 0, 0);
        // R5 BCD
        m_bcd = 1'b1;
        set_pre_load("R5", 24'h999999);
        drv("R5", 1, 1, 0, 0, 0, 0);
        drv("R5", 1, 0, 0, 0, 0, 0);
        set_pre_load("R5", 24'h000129);
        drv("R5", 1, 1, 0, 0, 0, 0);
        drv("R5", 1, 0, 0, 0, 0, 0);
        drv("R5", 1, 0, 0, 0, 0, 0);
        m_bcd = 1'b0;
        // R6 modulo-N
        m_mode = 2'd1;
        set_pre_load("R6", 24'h000005);
        drv("R6", 1, 1, 0, 0, 0, 0);
        drv("R6", 1, 0, 0, 0, 0, 0);
        drv("R6", 1, 0, 0, 0, 0, 0);
        drv("R6", 1, 1, 0, 0, 0, 0);
        // R7 range limit
        m_mode = 2'd2;
        set_pre_load("R7", 24'h000003);
        drv("R7", 1, 1, 0, 0, 0, 0);
        drv("R7", 1, 1, 0, 0, 0, 0);
        drv("R7", 1, 0, 0, 0, 0, 0);
        set_pre_load("R7", 24'h000000);
        drv("R7", 1, 0, 0, 0, 0, 0);
        drv("R7", 1, 1, 0, 0, 0, 0);
        // R8 non-recycle
        m_mode = 2'd3;
        set_pre_load("R8", 24'h000001);
        drv("R8", 1, 0, 0, 0, 0, 0);
        drv("R8", 1, 0, 0, 0, 0, 0);
        drv("R8", 1, 0, 0, 0, 0, 0);
        drv("R8", 1, 1, 0, 0, 0, 0);
        drv("R8", 0, 0, 1, 0, 0, 0);
        drv("R8", 1, 0, 0, 0, 0, 0);
        m_bcd = 1'b1;
        set_pre_load("R8", 24'h999998);
        drv("R8", 1, 1, 0, 0, 0, 0);
        drv("R8", 1, 1, 0, 0, 0, 0);
        drv("R8", 1, 0, 0, 1, 0, 0);
        idle("R8");
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        finish_up();
    end
endmodule